// File: doc/BRIEF.md
# Programmable Three-Channel Interval Timer

The block holds three 16-bit down-counters that sit behind a byte-wide register interface. There is one data address per counter and one write-only control address. Each control byte picks a counter and stores three settings for it: how its bytes are read and written, its counting mode, and whether it counts in binary or in packed BCD. Each counter has its own clock input, gate input and output. A counter steps once on every rising edge of its clock input, which is sampled in the system clock domain, and only while its gate is high.

The rate-generator mode and the square-wave mode are the periodic modes, and both are fully built. They are meant for periodic interrupt ticks and for dividing a clock. The output of one counter can be wired to the clock input of the next counter, so that the first acts as a prescaler. The remaining mode codes are accepted and stored, but a counter in one of those modes stays idle with its output high. A latch command freezes a snapshot of a running count, and that snapshot can then be read back without disturbing the count.

Top module: `interval_timer`

## Requirements
- R1: After reset every output is high. A counter makes no pulses until it has received a control byte that selects a periodic mode and then a complete count value.
- R2: Control writes go to address 3. Control bits 7:6 select the counter (00, 01 or 10 selects counter 0, 1 or 2). The value 11 is ignored and leaves every counter's settings and byte sequence unchanged.
- R3: Control bits 5:4 set the access sequence. 01 reads and writes the low byte only, and the high byte is then written as zero. 10 reads and writes the high byte only, and the low byte is then written as zero. 11 reads and writes the low byte first and the high byte second. Each control write restarts both byte sequences at the low byte.
- R4: Control bits 5:4 equal to 00 latch the selected counter's current count into a snapshot without changing its settings. Reads return the snapshot until it has been read completely, while counting goes on. Later reads return the live count. A further latch command while a snapshot is held is ignored.
- R5: Control bits 3:1 select the mode. Code 010 and code 110 give the rate generator. Code 011 and code 111 give the square wave. Codes 000, 001, 100 and 101 are stored, but the counter stops and holds its output high, so the byte 0x30 halts counter 0.
- R6: Control bit 0 set to 1 makes the counter count in four-digit packed BCD. Set to 0, it counts in 16-bit binary.
- R7: In the rate generator mode with a load value N of 2 or more, the output is low for exactly one counter clock out of every N clocks, when the count reaches 1. The counter then reloads.
- R8: In the square-wave mode with load value N, the output is high for ceil(N/2) counter clocks and low for floor(N/2) counter clocks.
- R9: While a counter's gate input is low, its count does not change.
- R10: A count written to a running counter takes effect at its next reload, and the period in progress completes with the old value. The first count after a control write is loaded on the next counter clock edge.
- R11: A counter steps on each rising edge of its clock input. When output 0 drives the clock input of counter 1, the period of counter 1 is the product of the two load values.
- R12: If a latch command arrives in the same system cycle as a count step, the snapshot holds the count from before the step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe, one cycle per byte |
| rd_en_i | input | 1 | Register read strobe, one cycle per byte |
| addr_i | input | 2 | 0 to 2 select a counter, 3 selects the control register |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the addressed counter, valid while rd_en_i is high |
| tclk_i | input | 3 | Counter clock inputs, one bit per counter |
| tgate_i | input | 3 | Counter gate inputs |
| tout_o | output | 3 | Counter outputs |

## Verification
Two things can happen in the same system cycle: a latch command written over the bus, and a count step caused by a rising edge on the counter clock. The bench raises counter 0's clock input in the same cycle in which it writes the latch byte. It then reads the snapshot and the live count. The snapshot must equal the count from before the step, and the live count must be one lower. A write that completes a new count while the counter is running is also checked: the period already in progress must finish with the old count.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
  localparam int N_CTR  = 3;
  localparam int DATA_W = 8;
  localparam int CNT_W  = 2 * DATA_W;
  localparam int DIG_N  = CNT_W / 4;
  localparam int ADDR_W = $clog2(N_CTR + 1);
  localparam int MODE_W = 3;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'b00,
    ACC_LO    = 2'b01,
    ACC_HI    = 2'b10,
    ACC_LOHI  = 2'b11
  } acc_e;

  typedef struct packed {
    logic [MODE_W-1:0] mode;
    acc_e              acc;
    logic              bcd;
  } cfg_t;

  // codes 110/111 alias modes 2/3
  function automatic logic [MODE_W-1:0] norm_mode(input logic [MODE_W-1:0] code);
    return (code[2:1] == 2'b11) ? {1'b0, code[1:0]} : code;
  endfunction

  function automatic logic [CNT_W-1:0] dec_one(input logic [CNT_W-1:0] v, input logic bcd);
    logic [CNT_W-1:0] r;
    logic borrow;
    r = v - 1'b1;
    if (bcd) begin
      r = v;
      borrow = 1'b1;
      for (int d = 0; d < DIG_N; d++) begin
        if (borrow) begin
          if (v[d*4 +: 4] == 4'd0) r[d*4 +: 4] = 4'd9;
          else begin
            r[d*4 +: 4] = v[d*4 +: 4] - 4'd1;
            borrow = 1'b0;
          end
        end
      end
    end
    return r;
  endfunction

  // floor(N/2); a zero load stands for the full range
  function automatic logic [CNT_W-1:0] half_of(input logic [CNT_W-1:0] v, input logic bcd);
    logic [CNT_W-1:0] r;
    logic rem;
    logic [4:0] val;
    if (v == '0) begin
      r = bcd ? {4'd5, {(CNT_W-4){1'b0}}} : {1'b1, {(CNT_W-1){1'b0}}};
    end else if (!bcd) begin
      r = v >> 1;
    end else begin
      r = '0;
      rem = 1'b0;
      for (int d = DIG_N - 1; d >= 0; d--) begin
        val = {1'b0, v[d*4 +: 4]} + (rem ? 5'd10 : 5'd0);
        r[d*4 +: 4] = val[4:1];
        rem = val[0];
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/itmr_ctrl_dec.sv
module itmr_ctrl_dec
  import itmr_pkg::*;
(
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [N_CTR-1:0]  ctl_we_o,
  output logic [N_CTR-1:0]  latch_o,
  output logic [N_CTR-1:0]  data_we_o,
  output cfg_t              cfg_o
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(N_CTR);

  logic       ctrl_hit;
  logic [1:0] sel;
  acc_e       acc;

  assign ctrl_hit = wr_i && (addr_i == CTRL_ADDR);
  assign sel      = wdata_i[7:6];
  assign acc      = acc_e'(wdata_i[5:4]);

  assign cfg_o.mode = norm_mode(wdata_i[3:1]);
  assign cfg_o.acc  = acc;
  assign cfg_o.bcd  = wdata_i[0];

  for (genvar i = 0; i < N_CTR; i++) begin : g_dec
    logic hit;
    assign hit          = ctrl_hit && (sel == 2'(i));
    assign ctl_we_o[i]  = hit && (acc != ACC_LATCH);
    assign latch_o[i]   = hit && (acc == ACC_LATCH);
    assign data_we_o[i] = wr_i && (addr_i == ADDR_W'(i));
  end
endmodule

// File: rtl/itmr_counter.sv
module itmr_counter
  import itmr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctl_we_i,
  input  cfg_t              ctl_cfg_i,
  input  logic              latch_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_i,
  input  logic              tclk_i,
  input  logic              gate_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              out_o,
  output logic [MODE_W-1:0] mode_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [CNT_W-1:0]  snap_o,
  output logic              run_o,
  output logic              tick_o,
  output logic              held_o
);
  cfg_t             cfg_q;
  logic [CNT_W-1:0] cnt_q, reload_q, pend_q, pend_d, snap_q, src;
  logic             run_q, load_req_q, tclk_q, wr_hi_q, rd_hi_q, held_q;
  logic             tick, wr_done, periodic, hi_sel;

  assign tick     = tclk_i && !tclk_q;
  assign periodic = (cfg_q.mode == 3'd2) || (cfg_q.mode == 3'd3);

  always_comb begin
    wr_done = 1'b0;
    pend_d  = pend_q;
    if (wr_i) begin
      case (cfg_q.acc)
        ACC_LO: begin
          pend_d  = {{DATA_W{1'b0}}, wdata_i};
          wr_done = 1'b1;
        end
        ACC_HI: begin
          pend_d  = {wdata_i, {DATA_W{1'b0}}};
          wr_done = 1'b1;
        end
        ACC_LOHI: begin
          if (!wr_hi_q) pend_d[DATA_W-1:0] = wdata_i;
          else begin
            pend_d[CNT_W-1:DATA_W] = wdata_i;
            wr_done = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q      <= '{mode: 3'd0, acc: ACC_LOHI, bcd: 1'b0};
      cnt_q      <= '0;
      reload_q   <= '0;
      pend_q     <= '0;
      snap_q     <= '0;
      run_q      <= 1'b0;
      load_req_q <= 1'b0;
      tclk_q     <= 1'b0;
      wr_hi_q    <= 1'b0;
      rd_hi_q    <= 1'b0;
      held_q     <= 1'b0;
    end else begin
      tclk_q <= tclk_i;
      if (ctl_we_i) begin
        cfg_q      <= ctl_cfg_i;
        run_q      <= 1'b0;
        load_req_q <= 1'b0;
        wr_hi_q    <= 1'b0;
        rd_hi_q    <= 1'b0;
        held_q     <= 1'b0;
      end else begin
        if (wr_i) begin
          pend_q <= pend_d;
          if (cfg_q.acc == ACC_LOHI) wr_hi_q <= !wr_hi_q;
          if (wr_done && !run_q) load_req_q <= 1'b1;
        end
        if (tick && load_req_q && periodic) begin
          cnt_q      <= pend_q;
          reload_q   <= pend_q;
          run_q      <= 1'b1;
          load_req_q <= 1'b0;
        end else if (tick && run_q && gate_i) begin
          if (cnt_q == CNT_W'(1)) begin
            cnt_q    <= pend_q;
            reload_q <= pend_q;
          end else begin
            cnt_q <= dec_one(cnt_q, cfg_q.bcd);
          end
        end
        if (rd_i) begin
          if (cfg_q.acc == ACC_LOHI) rd_hi_q <= !rd_hi_q;
          if (held_q && (cfg_q.acc != ACC_LOHI || rd_hi_q)) held_q <= 1'b0;
        end
        // snapshot takes the pre-step count
        if (latch_i && !held_q) begin
          snap_q  <= cnt_q;
          held_q  <= 1'b1;
          rd_hi_q <= 1'b0;
        end
      end
    end
  end

  assign src     = held_q ? snap_q : cnt_q;
  assign hi_sel  = (cfg_q.acc == ACC_HI) || ((cfg_q.acc == ACC_LOHI) && rd_hi_q);
  assign rdata_o = hi_sel ? src[CNT_W-1:DATA_W] : src[DATA_W-1:0];

  always_comb begin
    if (!run_q)                   out_o = 1'b1;
    else if (cfg_q.mode == 3'd2)  out_o = (cnt_q != CNT_W'(1));
    else                          out_o = (cnt_q == '0) || (cnt_q > half_of(reload_q, cfg_q.bcd));
  end

  assign mode_o = cfg_q.mode;
  assign cnt_o  = cnt_q;
  assign snap_o = snap_q;
  assign run_o  = run_q;
  assign tick_o = tick;
  assign held_o = held_q;
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import itmr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [N_CTR-1:0]  tclk_i,
  input  logic [N_CTR-1:0]  tgate_i,
  output logic [N_CTR-1:0]  tout_o
);
  logic [N_CTR-1:0]             ctl_we, latch, data_we;
  cfg_t                         cfg;
  logic [N_CTR-1:0][DATA_W-1:0] rd_byte;
  logic [N_CTR-1:0][MODE_W-1:0] mode_w;
  logic [N_CTR-1:0][CNT_W-1:0]  cnt_w, snap_w;
  logic [N_CTR-1:0]             run_w, tick_w, held_w;

  itmr_ctrl_dec u_dec (
    .wr_i     (wr_en_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .ctl_we_o (ctl_we),
    .latch_o  (latch),
    .data_we_o(data_we),
    .cfg_o    (cfg)
  );

  for (genvar i = 0; i < N_CTR; i++) begin : g_ctr
    itmr_counter u_ctr (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .ctl_we_i (ctl_we[i]),
      .ctl_cfg_i(cfg),
      .latch_i  (latch[i]),
      .wr_i     (data_we[i]),
      .wdata_i  (wdata_i),
      .rd_i     (rd_en_i && (addr_i == ADDR_W'(i))),
      .tclk_i   (tclk_i[i]),
      .gate_i   (tgate_i[i]),
      .rdata_o  (rd_byte[i]),
      .out_o    (tout_o[i]),
      .mode_o   (mode_w[i]),
      .cnt_o    (cnt_w[i]),
      .snap_o   (snap_w[i]),
      .run_o    (run_w[i]),
      .tick_o   (tick_w[i]),
      .held_o   (held_w[i])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < N_CTR; i++) begin
      if (addr_i == ADDR_W'(i)) rdata_o = rd_byte[i];
    end
  end
endmodule

// File: rtl/interval_timer_chk.sv
module interval_timer_chk
  import itmr_pkg::*;
(
  input logic                             clk_i,
  input logic                             rst_ni,
  input logic                             wr_en_i,
  input logic                             rd_en_i,
  input logic [ADDR_W-1:0]                addr_i,
  input logic [DATA_W-1:0]                wdata_i,
  input logic [N_CTR-1:0]                 tgate_i,
  input logic [N_CTR-1:0]                 tout_o,
  input logic [N_CTR-1:0]                 ctl_we,
  input logic [N_CTR-1:0][MODE_W-1:0]     mode_w,
  input logic [N_CTR-1:0][CNT_W-1:0]      cnt_w,
  input logic [N_CTR-1:0][CNT_W-1:0]      snap_w,
  input logic [N_CTR-1:0]                 run_w,
  input logic [N_CTR-1:0]                 tick_w,
  input logic [N_CTR-1:0]                 held_w
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(N_CTR);

  logic ctrl_wr;
  assign ctrl_wr = wr_en_i && (addr_i == CTRL_ADDR);

  AST_ILLEGAL_SEL_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni) (ctrl_wr && wdata_i[7:6] == 2'b11) |=> $stable(mode_w)); // R2
  AST_MODE_ALIAS: assert property (@(posedge clk_i) disable iff (!rst_ni) (ctrl_wr && wdata_i[7:6] == 2'b00 && wdata_i[5:4] != 2'b00 && wdata_i[3:2] == 2'b11) |=> (mode_w[0][2] == 1'b0)); // R5

  for (genvar i = 0; i < N_CTR; i++) begin : g_chk
    AST_IDLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni) !run_w[i] |-> tout_o[i]); // R1
    AST_GATE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni) (run_w[i] && !tgate_i[i] && !ctl_we[i]) |=> $stable(cnt_w[i])); // R9
    AST_ONE_CLK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni) (run_w[i] && mode_w[i] == 3'd2 && !tout_o[i] && tick_w[i] && tgate_i[i] && !ctl_we[i]) |=> tout_o[i]); // R7
    AST_SNAP_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni) (held_w[i] && !ctl_we[i] && !(rd_en_i && addr_i == ADDR_W'(i))) |=> $stable(snap_w[i])); // R4
  end
endmodule

bind interval_timer interval_timer_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .wr_en_i(wr_en_i),
  .rd_en_i(rd_en_i),
  .addr_i (addr_i),
  .wdata_i(wdata_i),
  .tgate_i(tgate_i),
  .tout_o (tout_o),
  .ctl_we (ctl_we),
  .mode_w (mode_w),
  .cnt_w  (cnt_w),
  .snap_w (snap_w),
  .run_w  (run_w),
  .tick_w (tick_w),
  .held_w (held_w)
);

// File: tb/interval_timer_bench.sv
module interval_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [2:0] tclk_r = '0, tgate = 3'b111, tout, tclk;
  logic       chain = 1'b0;
  int         errors = 0, checks = 0;
  bit         done = 1'b0;
  int         h, l;

  always #2 clk = ~clk;

  assign tclk = {tclk_r[2], chain ? tout[0] : tclk_r[1], tclk_r[0]};

  interval_timer u_interval_timer (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .tclk_i(tclk), .tgate_i(tgate), .tout_o(tout)
  );

  // {control byte, load value, N in clocks}
  localparam logic [39:0] VEC [11] = '{
    {8'h34, 16'h0005, 16'd5},   // R7 binary
    {8'h36, 16'h0006, 16'd6},   // R8 even
    {8'h36, 16'h0007, 16'd7},   // R8 odd
    {8'h35, 16'h0012, 16'd12},  // R6 BCD rate
    {8'h37, 16'h0011, 16'd11},  // R6 BCD square
    {8'h3C, 16'h0004, 16'd4},   // R5 code 110
    {8'h3E, 16'h0005, 16'd5},   // R5 code 111
    {8'h74, 16'h0003, 16'd3},   // R2 counter 1
    {8'hB6, 16'h0008, 16'd8},   // R2 counter 2
    {8'h14, 16'h0009, 16'd9},   // R3 low byte only
    {8'h24, 16'h0100, 16'd256}  // R3 high byte only
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic rd16(input logic [1:0] a, output int v);
    logic [7:0] lo, hi;
    rd(a, lo); rd(a, hi);
    v = {hi, lo};
  endtask

  task automatic tick(input int c);
    @(negedge clk); tclk_r[c] = 1'b1;
    @(negedge clk); tclk_r[c] = 1'b0;
  endtask

  task automatic measure(input int c, output int hh, output int ll);
    int g;
    g = 0;
    hh = 0; ll = 0;
    while (tout[c] && g < 2000) begin tick(c); g++; end
    while (!tout[c] && g < 2000) begin tick(c); g++; end
    hh = 1;
    while (g < 2000) begin tick(c); g++; if (tout[c]) hh++; else break; end
    ll = 1;
    while (g < 2000) begin tick(c); g++; if (!tout[c]) ll++; else break; end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    int v, cnt_low, f1, f2, f3, n;
    logic [1:0] ctr;
    logic [7:0] ctl;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(tout == 3'b111, "R1 reset outputs", tout, 7);
    cnt_low = 0;
    for (int k = 0; k < 5; k++) begin tick(0); if (!tout[0]) cnt_low++; end
    check(cnt_low == 0, "R1 unprogrammed no pulse", cnt_low, 0);

    // table walk: R7/R8 timing across modes, radices, counters and access sequences
    for (int e = 0; e < 11; e++) begin
      ctl = VEC[e][39:32];
      ctr = ctl[7:6];
      n   = int'(VEC[e][15:0]);
      wr(2'd3, ctl);
      if (ctl[5:4] == 2'b01) wr(ctr, VEC[e][23:16]);
      else if (ctl[5:4] == 2'b10) wr(ctr, VEC[e][31:24]);
      else begin wr(ctr, VEC[e][23:16]); wr(ctr, VEC[e][31:24]); end
      measure(int'(ctr), h, l);
      if (ctl[2:1] == 2'b10) begin
        check(h == n - 1, $sformatf("R7 vec%0d high", e), h, n - 1);
        check(l == 1, $sformatf("R7 vec%0d low", e), l, 1);
      end else begin
        check(h == (n + 1) / 2, $sformatf("R8 vec%0d high", e), h, (n + 1) / 2);
        check(l == n / 2, $sformatf("R8 vec%0d low", e), l, n / 2);
      end
    end

    // R4 latch while counting
    wr(2'd3, 8'h34); wr(2'd0, 8'hE8); wr(2'd0, 8'h03);
    for (int k = 0; k < 11; k++) tick(0);
    wr(2'd3, 8'h00);
    for (int k = 0; k < 5; k++) tick(0);
    rd16(2'd0, v);
    check(v == 990, "R4 snapshot", v, 990);
    rd16(2'd0, v);
    check(v == 985, "R4 live after snapshot", v, 985);

    // R12 latch and step in the same cycle
    @(negedge clk); tclk_r[0] = 1'b1; wr_en = 1'b1; addr = 2'd3; wdata = 8'h00;
    @(negedge clk); tclk_r[0] = 1'b0; wr_en = 1'b0;
    rd16(2'd0, v);
    check(v == 985, "R12 snapshot pre-step", v, 985);
    rd16(2'd0, v);
    check(v == 984, "R12 live post-step", v, 984);

    // R9 gate low holds the count
    tgate[0] = 1'b0;
    for (int k = 0; k < 5; k++) tick(0);
    rd16(2'd0, v);
    check(v == 984, "R9 gate hold", v, 984);
    tgate[0] = 1'b1;

    // R2 illegal select leaves counter 0 in two-byte access, still counting
    wr(2'd3, 8'hD0);
    tick(0);
    rd16(2'd0, v);
    check(v == 983, "R2 illegal select ignored", v, 983);

    // R10 new count takes effect at next reload
    wr(2'd3, 8'h34); wr(2'd0, 8'h05); wr(2'd0, 8'h00);
    measure(0, h, l);
    wr(2'd0, 8'h03); wr(2'd0, 8'h00);
    v = 0;
    while (tout[0] && v < 50) begin tick(0); v++; end
    check(v == 4, "R10 old period completes", v, 4);
    tick(0);
    h = 1;
    while (h < 50) begin tick(0); if (tout[0]) h++; else break; end
    check(h == 2, "R10 new period high", h, 2);

    // R5 mode 0 halts the counter
    wr(2'd3, 8'h30);
    cnt_low = 0;
    for (int k = 0; k < 20; k++) begin tick(0); if (!tout[0]) cnt_low++; end
    check(cnt_low == 0, "R5 mode 0 stops pulses", cnt_low, 0);

    // R11 chaining: period of counter 1 in counter 0 clocks
    chain = 1'b1;
    wr(2'd3, 8'h34); wr(2'd0, 8'h04); wr(2'd0, 8'h00);
    wr(2'd3, 8'h74); wr(2'd1, 8'h03); wr(2'd1, 8'h00);
    f1 = -1; f2 = -1; f3 = -1;
    for (int k = 0; k < 100; k++) begin
      logic prev;
      prev = tout[1];
      tick(0);
      if (prev && !tout[1]) begin
        if (f1 < 0) f1 = k; else if (f2 < 0) f2 = k; else if (f3 < 0) f3 = k;
      end
    end
    check(f3 - f2 == 12, "R11 chained period", f3 - f2, 12);
    chain = 1'b0;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule